// File: doc/BRIEF.md
# Sector Word Reader Bus Front End

This block is the host-facing slave of a storage sector reader. A bus master first sets a 28-bit logical block address with two 16-bit writes that are told apart by address bit 0. It then reads the sector's contents one 16-bit word per read strobe. The block does not talk to the storage device itself. It hands each read to a neighbouring sector sequencer over a request/done handshake, and it asks that sequencer for a device soft reset when a fetch fails.

Every address write sends the sequencer a one-cycle "address changed" pulse, so the next read starts a fresh sector command rather than continuing from a cached sector. A failed fetch raises the error output and triggers a soft reset. The status is then cleared and the fetch is retried, and the master sees nothing of this except a longer wait before ACK. ACK is held for a fixed number of cycles, after which the slave drops it on its own. The chip reset and a host restart input both bring the whole reader back to its initial state and run the start-up delay.

Top module: `wb_sector_front`

## Requirements
- R1: A write strobe (stb=1, we=1) with address bit 0 = 0 loads LBA bits 15:0 from write data bits 15:0 and leaves LBA bits 27:16 unchanged.
- R2: A write strobe with address bit 0 = 1 loads LBA bits 23:16 from write data bits 7:0 and LBA bits 27:24 from write data bits 11:8. It leaves LBA bits 15:0 unchanged and ignores write data bits 15:12.
- R3: Each accepted address write produces exactly one one-cycle pulse on `lba_new_o`, in the same cycle that ACK first rises.
- R4: A read strobe (stb=1, we=0) holds `fetch_req_o` until `fetch_done_i`. After a done without error, ACK, `dat_oe_o` and the returned word on `dat_o` all appear together one cycle later.
- R5: ACK stays high for exactly ACK_CYCLES consecutive cycles for every read and every write, and then falls without any action by the master.
- R6: A done that carries `fetch_err_i` sets `err_o` in the next cycle and holds `dev_rst_o` until `dev_rst_done_i`. After that, `lba_new_o` pulses once (status cleared) and the fetch is requested again. No ACK is given until a fetch succeeds.
- R7: `err_o` returns low on the next successful fetch, so it is already low in the cycle ACK rises for that read.
- R8: While no transfer is being acknowledged, ACK and `dat_oe_o` are low. `dat_oe_o` also stays low throughout a write's ACK.
- R9: While `rst` or `host_rst_i` is high, and in the cycle after it, ACK, `dat_oe_o`, `err_o`, `word_tag_o` and the LBA are all 0 and `dev_rst_o` is 1. After `dev_rst_done_i`, strobes are ignored for RST_WAIT cycles, with no ACK and no LBA change.
- R10: `word_tag_o` pulses high for exactly one cycle, in the cycle the returned word first appears with ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset |
| host_rst_i | input | 1 | Synchronous restart request from the host side |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Bus write enable |
| adr0_i | input | 1 | Address bit 0: selects the LBA low or high half |
| dat_i | input | 16 | Bus write data |
| dat_o | output | 16 | Bus read data (last fetched word) |
| dat_oe_o | output | 1 | Read-data drive enable |
| ack_o | output | 1 | Bus acknowledge |
| word_tag_o | output | 1 | One-cycle pulse: a fresh word is on dat_o |
| err_o | output | 1 | Device reported an error on the last fetch |
| lba_o | output | 28 | Current logical block address |
| lba_new_o | output | 1 | Pulse: drop cached sector state |
| fetch_req_o | output | 1 | Request the next word from the sequencer |
| fetch_done_i | input | 1 | Sequencer finished the request |
| fetch_err_i | input | 1 | Qualifies fetch_done_i as a failure |
| fetch_word_i | input | 16 | Word delivered with fetch_done_i |
| dev_rst_o | output | 1 | Request a device soft reset |
| dev_rst_done_i | input | 1 | Soft reset finished |

## Verification
The embedded properties check, on every cycle, that a successful done is followed by ACK, drive enable, the tag and the captured word together. They also check that the tag and the address-changed signal are single-cycle pulses, that the drive enable is never high without ACK, and that the error output only rises after a failed done. Only the bench scenarios can show the following: the ACK width count, the LBA bit mapping, the ignored upper high-half bits, the transparent retry sequence after one or two injected failures, and the ignoring of strobes during the post-reset wait. The bench covers these by sweeping sequencer latencies and walking-bit address patterns.

// File: rtl/fe_pkg.sv
package fe_pkg;
  typedef enum logic [2:0] {
    ST_RST     = 3'd0,
    ST_DELAY   = 3'd1,
    ST_IDLE    = 3'd2,
    ST_FETCH   = 3'd3,
    ST_RECOVER = 3'd4,
    ST_ACK     = 3'd5
  } fe_state_t;
endpackage

// File: rtl/fe_timer.sv
module fe_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          restart,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (restart)          cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/fe_lba_regs.sv
module fe_lba_regs #(
  parameter int LBA_W  = 28,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              restart,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [LBA_W-1:0]  lba
);
  localparam int HI_W = LBA_W - DATA_W;

  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;

  always_ff @(posedge clk) begin
    if (restart) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= wdata;
      if (wr_hi) hi_q <= wdata[HI_W-1:0];
    end
  end

  assign lba = {hi_q, lo_q};

  AST_LBA_HOLD: assert property (@(posedge clk) disable iff (restart)
    !(wr_lo || wr_hi) |=> $stable(lba)) else $error("lba changed without write"); // R1
  AST_HI_ONLY: assert property (@(posedge clk) disable iff (restart)
    (wr_hi && !wr_lo) |=> lba[DATA_W-1:0] == $past(lba[DATA_W-1:0])) else $error("low half touched"); // R2
endmodule

// File: rtl/fe_ctrl.sv
module fe_ctrl
  import fe_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ACK_CYCLES = 3,
  parameter int RST_WAIT   = 8,
  parameter int TW         = 4
) (
  input  logic              clk,
  input  logic              restart,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic              adr0_i,
  input  logic              fetch_done_i,
  input  logic              fetch_err_i,
  input  logic [DATA_W-1:0] fetch_word_i,
  input  logic              dev_rst_done_i,
  input  logic              tmr_zero,
  output logic              tmr_load,
  output logic [TW-1:0]     tmr_val,
  output logic              lba_wr_lo,
  output logic              lba_wr_hi,
  output logic              lba_new_o,
  output logic              ack_o,
  output logic              fetch_req_o,
  output logic              dev_rst_o,
  output logic [DATA_W-1:0] dat_o,
  output logic              dat_oe_o,
  output logic              word_tag_o,
  output logic              err_o
);
  localparam logic [TW-1:0] ACK_LOAD = TW'(ACK_CYCLES - 1);
  localparam logic [TW-1:0] RST_LOAD = TW'(RST_WAIT - 1);

  fe_state_t st_q;
  logic      idle_wr, idle_rd, fetch_ok, fetch_bad;

  assign idle_wr   = (st_q == ST_IDLE) && stb_i && we_i;
  assign idle_rd   = (st_q == ST_IDLE) && stb_i && !we_i;
  assign fetch_ok  = (st_q == ST_FETCH) && fetch_done_i && !fetch_err_i;
  assign fetch_bad = (st_q == ST_FETCH) && fetch_done_i && fetch_err_i;

  assign lba_wr_lo   = idle_wr && !adr0_i;
  assign lba_wr_hi   = idle_wr && adr0_i;
  assign ack_o       = (st_q == ST_ACK);
  assign fetch_req_o = (st_q == ST_FETCH);
  assign dev_rst_o   = (st_q == ST_RST) || (st_q == ST_RECOVER);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = ACK_LOAD;
    if (st_q == ST_RST && dev_rst_done_i) begin
      tmr_load = 1'b1;
      tmr_val  = RST_LOAD;
    end else if (idle_wr || fetch_ok) begin
      tmr_load = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (restart) begin
      st_q       <= ST_RST;
      dat_o      <= '0;
      dat_oe_o   <= 1'b0;
      word_tag_o <= 1'b0;
      err_o      <= 1'b0;
      lba_new_o  <= 1'b0;
    end else begin
      word_tag_o <= 1'b0;
      lba_new_o  <= 1'b0;
      case (st_q)
        ST_RST: if (dev_rst_done_i) st_q <= ST_DELAY;
        ST_DELAY: if (tmr_zero) st_q <= ST_IDLE;
        ST_IDLE: begin
          dat_oe_o <= 1'b0;
          if (idle_wr) begin
            lba_new_o <= 1'b1;
            st_q      <= ST_ACK;
          end else if (idle_rd) begin
            st_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (fetch_bad) begin
            err_o <= 1'b1;
            st_q  <= ST_RECOVER;
          end else if (fetch_ok) begin
            dat_o      <= fetch_word_i;
            dat_oe_o   <= 1'b1;
            word_tag_o <= 1'b1;
            err_o      <= 1'b0;
            st_q       <= ST_ACK;
          end
        end
        ST_RECOVER: begin
          if (dev_rst_done_i) begin
            lba_new_o <= 1'b1;
            st_q      <= ST_FETCH;
          end
        end
        ST_ACK: begin
          if (tmr_zero) begin
            dat_oe_o <= 1'b0;
            st_q     <= ST_IDLE;
          end
        end
        default: st_q <= ST_RST;
      endcase
    end
  end

  AST_DATA_ON_DONE: assert property (@(posedge clk) disable iff (restart)
    (fetch_req_o && fetch_done_i && !fetch_err_i) |=>
      (ack_o && dat_oe_o && word_tag_o && dat_o == $past(fetch_word_i))) else $error("read return"); // R4
  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (restart)
    $rose(err_o) |-> $past(fetch_done_i && fetch_err_i)) else $error("spurious error"); // R6
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (restart)
    (fetch_req_o && fetch_done_i && !fetch_err_i) |=> !err_o) else $error("error not cleared"); // R7
  AST_OE_WITH_ACK: assert property (@(posedge clk) disable iff (restart)
    dat_oe_o |-> ack_o) else $error("drive without ack"); // R8
  AST_TAG_PULSE: assert property (@(posedge clk) disable iff (restart)
    word_tag_o |=> !word_tag_o) else $error("tag too long"); // R10
  AST_LBA_NEW_PULSE: assert property (@(posedge clk) disable iff (restart)
    lba_new_o |=> !lba_new_o) else $error("lba_new too long"); // R3
endmodule

// File: rtl/wb_sector_front.sv
module wb_sector_front #(
  parameter int LBA_W      = 28,
  parameter int DATA_W     = 16,
  parameter int ACK_CYCLES = 3,
  parameter int RST_WAIT   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_rst_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic              adr0_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic [DATA_W-1:0] dat_o,
  output logic              dat_oe_o,
  output logic              ack_o,
  output logic              word_tag_o,
  output logic              err_o,
  output logic [LBA_W-1:0]  lba_o,
  output logic              lba_new_o,
  output logic              fetch_req_o,
  input  logic              fetch_done_i,
  input  logic              fetch_err_i,
  input  logic [DATA_W-1:0] fetch_word_i,
  output logic              dev_rst_o,
  input  logic              dev_rst_done_i
);
  localparam int MAXC = (ACK_CYCLES > RST_WAIT) ? ACK_CYCLES : RST_WAIT;
  localparam int TW   = $clog2(MAXC + 1);

  logic          restart;
  logic          tmr_load, tmr_zero, wr_lo, wr_hi;
  logic [TW-1:0] tmr_val;

  assign restart = rst || host_rst_i;

  fe_timer #(.TW(TW)) u_timer (
    .clk(clk), .restart(restart), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  fe_lba_regs #(.LBA_W(LBA_W), .DATA_W(DATA_W)) u_lba (
    .clk(clk), .restart(restart), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(dat_i), .lba(lba_o)
  );

  fe_ctrl #(.DATA_W(DATA_W), .ACK_CYCLES(ACK_CYCLES), .RST_WAIT(RST_WAIT), .TW(TW)) u_ctrl (
    .clk(clk), .restart(restart), .stb_i(stb_i), .we_i(we_i), .adr0_i(adr0_i),
    .fetch_done_i(fetch_done_i), .fetch_err_i(fetch_err_i), .fetch_word_i(fetch_word_i),
    .dev_rst_done_i(dev_rst_done_i), .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .lba_wr_lo(wr_lo), .lba_wr_hi(wr_hi), .lba_new_o(lba_new_o), .ack_o(ack_o),
    .fetch_req_o(fetch_req_o), .dev_rst_o(dev_rst_o), .dat_o(dat_o), .dat_oe_o(dat_oe_o),
    .word_tag_o(word_tag_o), .err_o(err_o)
  );

  AST_RESTART_QUIET: assert property (@(posedge clk)
    restart |=> (!ack_o && !dat_oe_o && !err_o && dev_rst_o)) else $error("restart state"); // R9
endmodule

// File: tb/wb_sector_front_tb.sv
module wb_sector_front_tb;
  localparam int ACKC = 3;
  localparam int RSTW = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1, host_rst_i = 1'b0;
  logic        stb_i = 1'b0, we_i = 1'b0, adr0_i = 1'b0;
  logic [15:0] dat_i = '0;
  logic [15:0] dat_o;
  logic        dat_oe_o, ack_o, word_tag_o, err_o, lba_new_o, fetch_req_o, dev_rst_o;
  logic [27:0] lba_o;
  logic        fetch_done_i = 1'b0, fetch_err_i = 1'b0, dev_rst_done_i = 1'b0;
  logic [15:0] fetch_word_i = '0;

  int checks = 0, fails = 0;
  int resp_lat = 0, err_left = 0, resp_idx = 0, rd_idx = 0;
  logic [27:0] exp_lba = '0;

  always #5 clk = ~clk;

  wb_sector_front #(.ACK_CYCLES(ACKC), .RST_WAIT(RSTW)) u_dut (
    .clk(clk), .rst(rst), .host_rst_i(host_rst_i), .stb_i(stb_i), .we_i(we_i), .adr0_i(adr0_i),
    .dat_i(dat_i), .dat_o(dat_o), .dat_oe_o(dat_oe_o), .ack_o(ack_o), .word_tag_o(word_tag_o),
    .err_o(err_o), .lba_o(lba_o), .lba_new_o(lba_new_o), .fetch_req_o(fetch_req_o),
    .fetch_done_i(fetch_done_i), .fetch_err_i(fetch_err_i), .fetch_word_i(fetch_word_i),
    .dev_rst_o(dev_rst_o), .dev_rst_done_i(dev_rst_done_i)
  );

  function automatic logic [15:0] word_of(input int i);
    return 16'h5A00 + 16'(i * 263);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // sequencer model: fetch responder
  initial forever begin
    @(negedge clk);
    if (fetch_req_o) begin
      repeat (resp_lat) @(negedge clk);
      fetch_done_i = 1'b1;
      if (err_left > 0) begin
        fetch_err_i = 1'b1;
        err_left--;
      end else begin
        fetch_word_i = word_of(resp_idx);
        resp_idx++;
      end
      @(negedge clk);
      fetch_done_i = 1'b0;
      fetch_err_i  = 1'b0;
    end
  end

  // sequencer model: soft reset responder
  initial forever begin
    @(negedge clk);
    dev_rst_done_i = dev_rst_o;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  task automatic wait_ready();
    int n = 0;
    while (dev_rst_o && n < 100) begin @(negedge clk); n++; end
    repeat (RSTW + 2) @(negedge clk);
  endtask

  task automatic do_write(input bit a0, input logic [15:0] d);
    int n = 0, news = 0, acks;
    @(negedge clk);
    stb_i = 1'b1; we_i = 1'b1; adr0_i = a0; dat_i = d;
    do begin @(negedge clk); n++; if (lba_new_o) news++; end while (!ack_o && n < 50);
    stb_i = 1'b0; we_i = 1'b0;
    chk(lba_new_o == 1'b1, "R3", "lba_new with first ack", lba_new_o, 1);
    chk(dat_oe_o == 1'b0, "R8", "oe during write ack", dat_oe_o, 0);
    if (a0) exp_lba = {d[11:0], exp_lba[15:0]};
    else    exp_lba = {exp_lba[27:16], d};
    chk(lba_o == exp_lba, a0 ? "R2" : "R1", "lba value", lba_o, exp_lba);
    acks = 1;
    @(negedge clk);
    while (ack_o && acks < 50) begin
      acks++;
      if (lba_new_o) news++;
      @(negedge clk);
    end
    chk(acks == ACKC, "R5", "write ack width", acks, ACKC);
    chk(news == 1, "R3", "lba_new pulse count", news, 1);
  endtask

  task automatic do_read(input int lat, input int nerr);
    int n = 0, news = 0, acks;
    bit saw_err = 0, saw_drst = 0, early_ack = 0;
    logic [15:0] exp;
    resp_lat = lat; err_left = nerr;
    @(negedge clk);
    stb_i = 1'b1; we_i = 1'b0;
    do begin
      @(negedge clk); n++;
      if (err_o) saw_err = 1;
      if (dev_rst_o) saw_drst = 1;
      if (lba_new_o) news++;
      if (ack_o && fetch_req_o) early_ack = 1;
    end while (!ack_o && n < 500);
    stb_i = 1'b0;
    exp = word_of(rd_idx);
    rd_idx++;
    chk(ack_o && dat_oe_o, "R4", "ack and oe together", {ack_o, dat_oe_o}, 3);
    chk(dat_o == exp, "R4", "read word", dat_o, exp);
    chk(word_tag_o == 1'b1, "R10", "tag with word", word_tag_o, 1);
    chk(err_o == 1'b0, "R7", "err low at ack", err_o, 0);
    chk(saw_err == (nerr > 0), "R6", "err seen", saw_err, nerr > 0);
    chk(saw_drst == (nerr > 0) && !early_ack, "R6", "soft reset seen", saw_drst, nerr > 0);
    chk(news == nerr, "R6", "status clears", news, nerr);
    acks = 1;
    @(negedge clk);
    chk(word_tag_o == 1'b0, "R10", "tag one cycle", word_tag_o, 0);
    while (ack_o && acks < 50) begin acks++; @(negedge clk); end
    chk(acks == ACKC, "R5", "read ack width", acks, ACKC);
    chk(dat_oe_o == 1'b0, "R8", "oe low after ack", dat_oe_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!ack_o && !dat_oe_o && !err_o && !word_tag_o && lba_o == 0 && dev_rst_o,
        "R9", "reset state", {ack_o, dat_oe_o, err_o, word_tag_o, dev_rst_o}, 1);
    rst = 1'b0;
    wait_ready();
    repeat (4) begin
      @(negedge clk);
      chk(!ack_o && !dat_oe_o, "R8", "idle quiet", {ack_o, dat_oe_o}, 0);
    end
    for (int lat = 0; lat < 6; lat++) do_read(lat, 0);
    for (int b = 0; b < 16; b++) do_write(1'b0, 16'(1 << b) ^ 16'h00F0);
    for (int b = 0; b < 16; b++) do_write(1'b1, 16'(1 << b) | 16'hF000);
    do_write(1'b1, 16'hFABC);
    do_write(1'b0, 16'h1234);
    for (int e = 1; e < 3; e++) do_read(e, e);
    for (int lat = 0; lat < 3; lat++) do_read(lat, 1);
    // host restart
    @(negedge clk);
    host_rst_i = 1'b1;
    @(negedge clk);
    host_rst_i = 1'b0;
    chk(!ack_o && !dat_oe_o && !err_o && lba_o == 0 && dev_rst_o, "R9", "host restart state",
        lba_o, 0);
    while (dev_rst_o) @(negedge clk);
    stb_i = 1'b1; we_i = 1'b1; adr0_i = 1'b0; dat_i = 16'hBEEF;
    begin
      bit seen = 0;
      repeat (2) begin @(negedge clk); if (ack_o) seen = 1; end
      stb_i = 1'b0; we_i = 1'b0;
      chk(!seen && lba_o == 0, "R9", "strobe ignored in wait", lba_o, 0);
    end
    exp_lba = '0;
    repeat (RSTW + 2) @(negedge clk);
    do_write(1'b0, 16'hC0DE);
    do_read(2, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule